// File: doc/BRIEF.md
# Timed DLL Bring-Up Sequencer

This block powers up the delay-locked loops of a memory PHY in a fixed order, without software timing. One master DLL and a group of per-byte slave DLLs each get three control outputs: a disable bit, an active-low reset and a phase setting. A one-cycle pulse on `start` begins a run. The block takes the phase settings for every DLL from one packed 32-bit word. It then moves the master through a three-step ladder: disabled and held in reset, enabled but still in reset, then released. Each step lasts a fixed number of microseconds. After the master finishes, all active slaves climb the same ladder together.

The number of active slaves follows a bus-width code. A 32-bit bus uses four slaves, and any other width uses two. Slaves that are not used in a run are forced off when the run starts. Every wait is counted in clock cycles, using a parameter that gives the number of clocks per microsecond. The block raises `done` for one cycle when the last wait has elapsed.

Top module: `dll_bringup_seq`

## Requirements
- R1: After reset, every DLL has disable=1, nreset=0 and phase=0, and `busy` and `done` are both 0.
- R2: In the first cycle after `start` is accepted, the master phase output equals bits 21:16 of `phase_word`, and it holds that value for the rest of the run.
- R3: Slave k (k=1..4) receives the 4-bit phase taken from bits 4k-1:4k-4 of the `phase_word` sampled at start. Slave 1 uses bits 3:0 and slave 4 uses bits 15:12.
- R4: A `bus_width_code` of 3'b011 makes slaves 1 to 4 active. Any other code makes slaves 1 and 2 active. From the first cycle of a run, inactive slaves have disable=1, nreset=0 and phase=0.
- R5: Step 1 of a ladder loads the phase, sets disable=1 and nreset=0, and lasts 2 us.
- R6: Step 2 sets disable=0 with nreset still 0, and lasts 22 us.
- R7: Step 3 sets nreset=1 with disable still 0, and lasts 22 us before the sequence moves on.
- R8: All active slaves change their disable and nreset outputs in the same cycle.
- R9: The slave ladder begins in the cycle after the master's step 3 ends. Until then, the slaves keep their previous outputs.
- R10: `busy` is high from the first cycle after `start` is accepted until the run ends. `done` is high for exactly one cycle, the first cycle in which `busy` is low again.
- R11: A `start` pulse while `busy` is high is ignored. Changes to `phase_word` and `bus_width_code` during a run have no effect on that run.
- R12: A wait of n microseconds lasts exactly n*CLKS_PER_US clock cycles. With the ladder above, a full run lasts 92*CLKS_PER_US cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins a run when idle |
| phase_word | input | 32 | Packed phase settings for the master and the slaves |
| bus_width_code | input | 3 | Data bus width code; 3'b011 means 32 bits |
| mst_dis | output | 1 | Master DLL disable |
| mst_rst_n | output | 1 | Master DLL reset, active low |
| mst_phase | output | 6 | Master DLL phase |
| slv_dis | output | 4 | Slave DLL disables; bit k-1 controls slave k |
| slv_rst_n | output | 4 | Slave DLL resets, active low |
| slv_phase | output | 16 | Slave phases; slice 4(k-1)+:4 controls slave k |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when a run ends |

## Verification
The hardest case to reach from the ports is proving that the slaves really wait for the master. After reset, the slaves already show disabled and in reset, so the ladder's first step cannot be seen. The bench therefore runs a second 32-bit sequence with a new phase word right after the first. Now the slaves start that run in the released state, and the bench can look at the last cycle of the master's step 3 and the cycle after it. It also starts a narrow run straight after a wide one, to see slaves 3 and 4 being forced off, and it pulses `start` and changes the inputs in the middle of a run to show they are ignored.

// File: rtl/dllseq_pkg.sv
package dllseq_pkg;

   // Action applied to one DLL lane when its apply strobe is high.
   typedef enum logic [1:0] {
      STEP_OFF = 2'd0,   // disabled, in reset, phase cleared
      STEP_DIS = 2'd1,   // load phase, disabled, in reset
      STEP_RST = 2'd2,   // enabled, still in reset
      STEP_RUN = 2'd3    // enabled, reset released
   } step_e;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_M_DIS = 3'd1,
      ST_M_RST = 3'd2,
      ST_M_RUN = 3'd3,
      ST_S_DIS = 3'd4,
      ST_S_RST = 3'd5,
      ST_S_RUN = 3'd6
   } seq_state_e;

endpackage

// File: rtl/dllseq_us_timer.sv
module dllseq_us_timer #(
   parameter int CLKS_PER_US = 250,
   parameter int US_W        = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [US_W-1:0] load_us,
   output logic            expired
);
   localparam int PRE_W = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
   localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(CLKS_PER_US - 1);

   logic             run_q;
   logic [PRE_W-1:0] pre_q;
   logic [US_W-1:0]  us_q;

   assign expired = run_q && (pre_q == '0) && (us_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         pre_q <= '0;
         us_q  <= '0;
      end else if (load) begin
         run_q <= 1'b1;
         pre_q <= PRE_TOP;
         us_q  <= load_us - 1'b1;
      end else if (run_q) begin
         if (pre_q != '0) begin
            pre_q <= pre_q - 1'b1;
         end else if (us_q != '0) begin
            us_q  <= us_q - 1'b1;
            pre_q <= PRE_TOP;
         end else begin
            run_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/dllseq_lane.sv
module dllseq_lane
   import dllseq_pkg::*;
#(
   parameter int PW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          apply,
   input  step_e         kind,
   input  logic [PW-1:0] phase_in,
   output logic          dis,
   output logic          rstn_o,
   output logic [PW-1:0] phase
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dis    <= 1'b1;
         rstn_o <= 1'b0;
         phase  <= '0;
      end else if (apply) begin
         unique case (kind)
            STEP_OFF: begin
               dis    <= 1'b1;
               rstn_o <= 1'b0;
               phase  <= '0;
            end
            STEP_DIS: begin
               dis    <= 1'b1;
               rstn_o <= 1'b0;
               phase  <= phase_in;
            end
            STEP_RST: begin
               dis    <= 1'b0;
               rstn_o <= 1'b0;
            end
            STEP_RUN: begin
               dis    <= 1'b0;
               rstn_o <= 1'b1;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/dllseq_ctrl.sv
module dllseq_ctrl
   import dllseq_pkg::*;
#(
   parameter int WAIT_DIS_US = 2,
   parameter int WAIT_RST_US = 22,
   parameter int WAIT_RUN_US = 22,
   parameter int US_W        = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            expired,
   output logic            accept,
   output logic            m_apply,
   output logic            s_apply,
   output step_e           kind,
   output logic            tmr_load,
   output logic [US_W-1:0] tmr_us,
   output logic            busy,
   output logic            done
);
   localparam logic [US_W-1:0] T_DIS = US_W'(WAIT_DIS_US);
   localparam logic [US_W-1:0] T_RST = US_W'(WAIT_RST_US);
   localparam logic [US_W-1:0] T_RUN = US_W'(WAIT_RUN_US);

   seq_state_e st_q, st_d;
   logic       fin;

   always_comb begin
      st_d     = st_q;
      accept   = 1'b0;
      m_apply  = 1'b0;
      s_apply  = 1'b0;
      kind     = STEP_OFF;
      tmr_load = 1'b0;
      tmr_us   = '0;
      fin      = 1'b0;
      unique case (st_q)
         ST_IDLE: if (start) begin
            accept = 1'b1; m_apply = 1'b1; kind = STEP_DIS;
            tmr_load = 1'b1; tmr_us = T_DIS; st_d = ST_M_DIS;
         end
         ST_M_DIS: if (expired) begin
            m_apply = 1'b1; kind = STEP_RST;
            tmr_load = 1'b1; tmr_us = T_RST; st_d = ST_M_RST;
         end
         ST_M_RST: if (expired) begin
            m_apply = 1'b1; kind = STEP_RUN;
            tmr_load = 1'b1; tmr_us = T_RUN; st_d = ST_M_RUN;
         end
         ST_M_RUN: if (expired) begin
            s_apply = 1'b1; kind = STEP_DIS;
            tmr_load = 1'b1; tmr_us = T_DIS; st_d = ST_S_DIS;
         end
         ST_S_DIS: if (expired) begin
            s_apply = 1'b1; kind = STEP_RST;
            tmr_load = 1'b1; tmr_us = T_RST; st_d = ST_S_RST;
         end
         ST_S_RST: if (expired) begin
            s_apply = 1'b1; kind = STEP_RUN;
            tmr_load = 1'b1; tmr_us = T_RUN; st_d = ST_S_RUN;
         end
         ST_S_RUN: if (expired) begin
            fin = 1'b1; st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
         done <= 1'b0;
      end else begin
         st_q <= st_d;
         done <= fin;
      end
   end

   assign busy = (st_q != ST_IDLE);
endmodule

// File: rtl/dll_bringup_seq.sv
module dll_bringup_seq
   import dllseq_pkg::*;
#(
   parameter int              CLKS_PER_US  = 250,
   parameter int              WAIT_DIS_US  = 2,
   parameter int              WAIT_RST_US  = 22,
   parameter int              WAIT_RUN_US  = 22,
   parameter int              WORD_W       = 32,
   parameter int              MPH_W        = 6,
   parameter int              MPH_LSB      = 16,
   parameter int              SPH_W        = 4,
   parameter int              NS_WIDE      = 4,
   parameter int              NS_NARROW    = 2,
   parameter int              BWC_W        = 3,
   parameter logic [BWC_W-1:0] BWC_WIDE    = 3'b011
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [WORD_W-1:0]        phase_word,
   input  logic [BWC_W-1:0]         bus_width_code,
   output logic                     mst_dis,
   output logic                     mst_rst_n,
   output logic [MPH_W-1:0]         mst_phase,
   output logic [NS_WIDE-1:0]       slv_dis,
   output logic [NS_WIDE-1:0]       slv_rst_n,
   output logic [NS_WIDE*SPH_W-1:0] slv_phase,
   output logic                     busy,
   output logic                     done
);
   localparam int MAX_US = (WAIT_DIS_US > WAIT_RST_US)
                         ? ((WAIT_DIS_US > WAIT_RUN_US) ? WAIT_DIS_US : WAIT_RUN_US)
                         : ((WAIT_RST_US > WAIT_RUN_US) ? WAIT_RST_US : WAIT_RUN_US);
   localparam int US_W = $clog2(MAX_US + 1);

   // Elaboration-time parameter checks.
   if (CLKS_PER_US < 1) begin : g_bad_clk
      $error("CLKS_PER_US must be at least 1");
   end
   if (WAIT_DIS_US < 1 || WAIT_RST_US < 1 || WAIT_RUN_US < 1) begin : g_bad_wait
      $error("every wait must be at least 1 us");
   end
   if (NS_NARROW < 1 || NS_NARROW > NS_WIDE) begin : g_bad_ns
      $error("NS_NARROW must lie in 1..NS_WIDE");
   end
   if (SPH_W * NS_WIDE > MPH_LSB) begin : g_overlap
      $error("slave phase nibbles overlap the master field");
   end
   if (MPH_LSB + MPH_W > WORD_W) begin : g_mst_range
      $error("master phase field exceeds the phase word");
   end

   logic            accept, m_apply, s_apply, tmr_load, expired;
   step_e           kind;
   logic [US_W-1:0] tmr_us;
   logic [WORD_W-1:0] word_q;
   logic            wide_q, wide_now, wide_eff;
   logic            unused_bits;

   assign wide_now    = (bus_width_code == BWC_WIDE);
   assign wide_eff    = accept ? wide_now : wide_q;
   assign unused_bits = ^word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         wide_q <= 1'b0;
      end else if (accept) begin
         word_q <= phase_word;
         wide_q <= wide_now;
      end
   end

   dllseq_ctrl #(
      .WAIT_DIS_US(WAIT_DIS_US), .WAIT_RST_US(WAIT_RST_US),
      .WAIT_RUN_US(WAIT_RUN_US), .US_W(US_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .expired(expired),
      .accept(accept), .m_apply(m_apply), .s_apply(s_apply), .kind(kind),
      .tmr_load(tmr_load), .tmr_us(tmr_us), .busy(busy), .done(done)
   );

   dllseq_us_timer #(.CLKS_PER_US(CLKS_PER_US), .US_W(US_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_us(tmr_us),
      .expired(expired)
   );

   dllseq_lane #(.PW(MPH_W)) u_mst (
      .clk(clk), .rst_n(rst_n), .apply(m_apply), .kind(kind),
      .phase_in(phase_word[MPH_LSB +: MPH_W]),
      .dis(mst_dis), .rstn_o(mst_rst_n), .phase(mst_phase)
   );

   for (genvar g = 0; g < NS_WIDE; g++) begin : g_slv
      logic  active, apply_g;
      step_e kind_g;
      if (g < NS_NARROW) begin : g_always
         assign active = 1'b1;
      end else begin : g_wide_only
         assign active = wide_eff;
      end
      assign apply_g = active ? s_apply : accept;
      assign kind_g  = active ? kind : STEP_OFF;
      dllseq_lane #(.PW(SPH_W)) u_lane (
         .clk(clk), .rst_n(rst_n), .apply(apply_g), .kind(kind_g),
         .phase_in(word_q[g*SPH_W +: SPH_W]),
         .dis(slv_dis[g]), .rstn_o(slv_rst_n[g]),
         .phase(slv_phase[g*SPH_W +: SPH_W])
      );
   end
endmodule

// File: rtl/dll_bringup_seq_chk.sv
module dll_bringup_seq_chk #(
   parameter int CLKS_PER_US = 250,
   parameter int WAIT_DIS_US = 2,
   parameter int MPH_W       = 6,
   parameter int NS          = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             mst_dis,
   input logic             mst_rst_n,
   input logic [MPH_W-1:0] mst_phase,
   input logic [NS-1:0]    slv_dis,
   input logic             busy,
   input logic             done
);
   logic [31:0] dis_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              dis_cnt <= '0;
      else if (!busy)          dis_cnt <= '0;
      else if (mst_dis)        dis_cnt <= dis_cnt + 1'b1;
   end

   a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   a_r2_phase_held: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(mst_phase));

   a_r9_master_first: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && |(slv_dis & ~$past(slv_dis))) |-> (mst_rst_n && !mst_dis));

   a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> !$rose(mst_dis));

   a_r7_release_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mst_rst_n) |-> (!mst_dis && $past(!mst_dis)));

   a_r12_step1_length: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $fell(mst_dis)) |-> (dis_cnt == 32'(WAIT_DIS_US * CLKS_PER_US)));
endmodule

bind dll_bringup_seq dll_bringup_seq_chk #(
   .CLKS_PER_US(CLKS_PER_US), .WAIT_DIS_US(WAIT_DIS_US),
   .MPH_W(MPH_W), .NS(NS_WIDE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .mst_dis(mst_dis),
   .mst_rst_n(mst_rst_n), .mst_phase(mst_phase), .slv_dis(slv_dis),
   .busy(busy), .done(done)
);

// File: tb/dll_bringup_seq_bench.sv
module dll_bringup_seq_bench;
   localparam int C   = 5;
   localparam int END = 92 * C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] phase_word = '0;
   logic [2:0]  bus_width_code = 3'b011;
   logic        mst_dis, mst_rst_n, busy, done;
   logic [5:0]  mst_phase;
   logic [3:0]  slv_dis, slv_rst_n;
   logic [15:0] slv_phase;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #2 clk = ~clk;

   dll_bringup_seq #(.CLKS_PER_US(C)) u_dll_bringup_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .phase_word(phase_word),
      .bus_width_code(bus_width_code), .mst_dis(mst_dis),
      .mst_rst_n(mst_rst_n), .mst_phase(mst_phase), .slv_dis(slv_dis),
      .slv_rst_n(slv_rst_n), .slv_phase(slv_phase), .busy(busy), .done(done)
   );

   task automatic expect_eq(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] slv_phase_exp(logic [31:0] w, logic [3:0] m);
      logic [15:0] r;
      for (int k = 0; k < 4; k++) r[k*4 +: 4] = m[k] ? w[k*4 +: 4] : 4'h0;
      return r;
   endfunction

   task automatic t_reset();
      @(negedge clk);
      expect_eq("R1", "mst_dis", 32'(mst_dis), 1);
      expect_eq("R1", "mst_rst_n", 32'(mst_rst_n), 0);
      expect_eq("R1", "mst_phase", 32'(mst_phase), 0);
      expect_eq("R1", "slv_dis", 32'(slv_dis), 4'hF);
      expect_eq("R1", "slv_rst_n", 32'(slv_rst_n), 0);
      expect_eq("R1", "slv_phase", 32'(slv_phase), 0);
      expect_eq("R1", "busy/done", {busy, done}, 0);
   endtask

   // One full run; disturb pulses start and changes inputs mid-run (R11).
   task automatic t_run(logic [31:0] w, logic [2:0] code, bit disturb, bit prev_run);
      logic [3:0] m;
      int dones;
      m = (code == 3'b011) ? 4'hF : 4'h3;
      dones = 0;
      @(negedge clk);
      phase_word = w; bus_width_code = code; start = 1'b1;
      for (int i = 1; i <= END + 2; i++) begin
         @(negedge clk);
         if (i == 1) start = 1'b0;
         if (disturb && i == 10) begin
            start = 1'b1; phase_word = ~w; bus_width_code = ~code;
         end
         if (disturb && i == 11) start = 1'b0;
         if (disturb && i == 24*C + 3) begin
            start = 1'b1; phase_word = 32'h0;
         end
         if (disturb && i == 24*C + 4) start = 1'b0;
         if (done) dones++;
         if (i == 1) begin
            expect_eq("R5", "mst step1", {mst_dis, mst_rst_n}, 2'b10);
            expect_eq("R2", "mst_phase", 32'(mst_phase), 32'(w[21:16]));
            expect_eq("R10", "busy start", 32'(busy), 1);
            expect_eq("R4", "inactive off", 32'(slv_dis & ~m), 32'(~m & 4'hF));
            expect_eq("R4", "inactive rst", 32'(slv_rst_n & ~m), 0);
            expect_eq("R4", "inactive phase", 32'(slv_phase & ~slv_phase_exp(32'hFFFF, m)), 0);
         end
         if (i == 2*C)     expect_eq("R12", "step1 end", 32'(mst_dis), 1);
         if (i == 2*C + 1) expect_eq("R6", "mst step2", {mst_dis, mst_rst_n}, 2'b00);
         if (i == 24*C)    expect_eq("R12", "step2 end", 32'(mst_rst_n), 0);
         if (i == 24*C + 1) expect_eq("R7", "mst step3", {mst_dis, mst_rst_n}, 2'b01);
         if (i == 46*C) begin
            expect_eq("R9", "slaves wait dis", 32'(slv_dis & m), prev_run ? 0 : 32'(m));
            expect_eq("R9", "slaves wait rst", 32'(slv_rst_n & m), prev_run ? 32'(m) : 0);
         end
         if (i == 46*C + 1) begin
            expect_eq("R5", "slv step1 dis", 32'(slv_dis & m), 32'(m));
            expect_eq("R5", "slv step1 rst", 32'(slv_rst_n & m), 0);
            expect_eq("R3", "slv_phase", 32'(slv_phase), 32'(slv_phase_exp(w, m)));
            expect_eq("R11", "mst_phase held", 32'(mst_phase), 32'(w[21:16]));
         end
         if (i == 48*C)     expect_eq("R12", "slv step1 end", 32'(slv_dis & m), 32'(m));
         if (i == 48*C + 1) expect_eq("R8", "slv step2 together", 32'(slv_dis & m), 0);
         if (i == 70*C)     expect_eq("R6", "slv step2 end", 32'(slv_rst_n & m), 0);
         if (i == 70*C + 1) expect_eq("R8", "slv step3 together", 32'(slv_rst_n & m), 32'(m));
         if (i == END) expect_eq("R12", "last wait", {busy, done}, 2'b10);
         if (i == END + 1) expect_eq("R10", "done pulse", {busy, done}, 2'b01);
      end
      expect_eq("R10", "done count", 32'(dones), 1);
      expect_eq("R4", "inactive end", 32'(slv_dis & ~m), 32'(~m & 4'hF));
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 200000) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_run(32'h002A_C3B5, 3'b011, 1'b0, 1'b0);
      t_run(32'h0015_7E29, 3'b011, 1'b0, 1'b1);
      t_run(32'h003F_4D6E, 3'b001, 1'b1, 1'b1);
      t_run(32'h0007_9A51, 3'b000, 1'b0, 1'b1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule